// File: doc/BRIEF.md
# Single-Pixel-Per-Frame Image Grabber

This block lets a slow host pull a complete image out of a fast pixel stream one pixel at a time. The imager delivers a frame of 361 pixels (a 19 by 19 array in column-major order, index 0 first and 360 last) as a stream of index, 6-bit value and a valid strobe. The grabber holds a pixel pointer. Once it is armed, it waits for the start of a fresh frame and then latches the stream pixel whose index equals the pointer. Capture is therefore limited to one pixel per frame, and a full dump spans at least 361 frames.

The host sees one 8-bit register. A write to it rewinds the pointer to the first pixel. A read returns the flags and the captured value. If the read found valid data, it also moves the pointer on, wrapping from 360 back to 0. Any access re-arms capture. A value that has been held is not refreshed by later frames, so it goes stale if the host waits.

Top module: `pixel_grabber`

## Requirements
- R1: The register reads as {start_of_frame (bit 7), data_valid (bit 6), pixel value (bits 5:0)}. All bits read 0 while data_valid is 0.
- R2: After reset the register reads 0x00, the pointer is at pixel 0, and capture is not armed, so frames that arrive before the first access are not captured.
- R3: A write rewinds the pointer to pixel 0, clears data_valid and arms capture. The next valid read returns pixel 0 with start_of_frame set.
- R4: A read that sees data_valid=1 advances the pointer by one and re-arms capture, so the next capture takes the following pixel index.
- R5: After the read of pixel 360 the pointer wraps to 0, and the next valid read shows start_of_frame again.
- R6: A read that sees data_valid=0 leaves the pointer unchanged and only re-arms capture.
- R7: After arming, a stream pixel is captured only once a pixel with index 0 (the start of a new frame) has been seen. Pixels of a frame already in progress are ignored.
- R8: Once a pixel is held, later frames do not overwrite it until the next access.
- R9: start_of_frame reads 1 exactly when data_valid is 1 and the held pixel is index 0.
- R10: When a read and a write occur in the same cycle, the write takes effect: the pointer goes to 0 and data_valid clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Stream pixel present this cycle |
| pix_index | input | 9 | Index of the stream pixel, 0..360 |
| pix_value | input | 6 | Value of the stream pixel |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_rd | input | 1 | One-cycle register read strobe; data is taken from reg_data in this same cycle |
| reg_data | output | 8 | Register read value |

## Verification
The hardest state to reach is the pointer wrap at pixel 360. Reaching it takes 361 successive valid reads, and each read needs a frame that both starts at index 0 and passes the pointed-at index. The bench gets there with shortened frames. Each frame carries only index 0, a neighbour of the target, the target itself and the next index, so the whole dump stays short while every value is still checked. It also sends a pixel that matches the pointer but arrives without a preceding frame start, to confirm that a partial frame is ignored.

// File: rtl/pg_pkg.sv
package pg_pkg;
    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_WAIT  = 2'd1,
        GS_HUNT  = 2'd2,
        GS_HELD  = 2'd3
    } grab_state_e;
endpackage

// File: rtl/pg_index_ctr.sv
module pg_index_ctr #(
    parameter int NPIX = 361,
    parameter int IW   = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] ptr_o
);
    localparam logic [IW-1:0] LAST = IW'(NPIX - 1);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else if (adv) begin
            if (st_q.ptr == LAST) st_d.ptr = '0;
            else                  st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= LAST);  // R5
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && st_q.ptr == LAST) |=> (st_q.ptr == '0));  // R5
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.ptr == '0));  // R3
endmodule

// File: rtl/pg_capture.sv
module pg_capture #(
    parameter int IW = 9,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          pix_valid,
    input  logic [IW-1:0] pix_index,
    input  logic [PW-1:0] pix_value,
    input  logic [IW-1:0] ptr,
    output logic          held_o,
    output logic [PW-1:0] data_o
);
    import pg_pkg::*;

    typedef struct packed {
        grab_state_e   st;
        logic [PW-1:0] data;
    } cap_t;

    cap_t c_d, c_q;
    logic frame_start;
    logic hit;

    assign frame_start = pix_valid && (pix_index == '0);
    assign hit         = pix_valid && (pix_index == ptr);

    always_comb begin
        c_d = c_q;
        if (arm) begin
            c_d.st = GS_WAIT;
        end else begin
            unique case (c_q.st)
                GS_WAIT: begin
                    if (frame_start) begin
                        if (ptr == '0) begin
                            c_d.st   = GS_HELD;
                            c_d.data = pix_value;
                        end else begin
                            c_d.st = GS_HUNT;
                        end
                    end
                end
                GS_HUNT: begin
                    if (hit) begin
                        c_d.st   = GS_HELD;
                        c_d.data = pix_value;
                    end
                end
                default: c_d = c_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: GS_IDLE, data: '0};
        else        c_q <= c_d;
    end

    assign held_o = (c_q.st == GS_HELD);
    assign data_o = c_q.data;

    AST_CAPTURE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_o) |-> $past(pix_valid && pix_index == ptr && !arm));  // R7
    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !arm) |=> (held_o && $stable(data_o)));  // R8
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !held_o);  // R3
endmodule

// File: rtl/pixel_grabber.sv
module pixel_grabber #(
    parameter int NPIX = 361,
    parameter int PW   = 6,
    parameter int IW   = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic [IW-1:0] pix_index,
    input  logic [PW-1:0] pix_value,
    input  logic          reg_wr,
    input  logic          reg_rd,
    output logic [PW+1:0] reg_data
);
    logic [IW-1:0] ptr;
    logic          held;
    logic [PW-1:0] data;
    logic          arm;
    logic          adv;

    assign arm = reg_wr || reg_rd;
    assign adv = reg_rd && held && !reg_wr;

    pg_index_ctr #(.NPIX(NPIX), .IW(IW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reg_wr),
        .adv   (adv),
        .ptr_o (ptr)
    );

    pg_capture #(.IW(IW), .PW(PW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .pix_valid (pix_valid),
        .pix_index (pix_index),
        .pix_value (pix_value),
        .ptr       (ptr),
        .held_o    (held),
        .data_o    (data)
    );

    always_comb begin
        reg_data = '0;
        if (held) reg_data = {(ptr == '0), 1'b1, data};
    end

    AST_NOVALID_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && !reg_data[PW]) |=> $stable(ptr));  // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_rd) |=> (ptr == '0 && reg_data == '0));  // R10
    AST_VALID_READ_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_data[PW] && ptr != IW'(NPIX - 1))
            |=> (ptr == $past(ptr) + 1'b1));  // R4
endmodule

// File: tb/tb_pixel_grabber.sv
module tb_pixel_grabber;
    localparam int CLK_PERIOD = 10;
    localparam int NPIX = 361;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       pix_valid = 0;
    logic [8:0] pix_index = '0;
    logic [5:0] pix_value = '0;
    logic       reg_wr = 0;
    logic       reg_rd = 0;
    logic [7:0] reg_data;

    int checks = 0;
    int errors = 0;
    int fnum   = 0;
    bit done   = 0;

    pixel_grabber dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_index(pix_index),
        .pix_value(pix_value), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_data(reg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] pval(int f, int i);
        return 6'((i * 5 + f * 11 + 3) & 63);
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic beat(int idx, logic [5:0] v);
        @(negedge clk);
        pix_valid = 1; pix_index = 9'(idx); pix_value = v;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pix_valid = 0;
        end
    endtask

    // shortened frame: start pixel, neighbour, target, next
    task automatic frame(int target);
        fnum++;
        beat(0, pval(fnum, 0));
        if (target > 1) beat(target - 1, pval(fnum, target - 1));
        if (target > 0) beat(target, pval(fnum, target));
        if (target < NPIX - 1) beat(target + 1, pval(fnum, target + 1));
        idle(1);
    endtask

    task automatic rd_expect(string req, logic [7:0] exp);
        @(negedge clk);
        chk(req, reg_data, exp);
        reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wr_pulse();
        @(negedge clk);
        reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R2 reset value", reg_data, 8'h00);
        frame(0);
        frame(0);
        @(negedge clk);
        chk("R2 no capture before arming", reg_data, 8'h00);
    endtask

    task automatic t_write_first();
        wr_pulse();
        @(negedge clk);
        chk("R3 write clears valid", reg_data, 8'h00);
        frame(0);
        rd_expect("R3 R1 R9 first pixel with sof", {2'b11, pval(fnum, 0)});
        frame(1);
        rd_expect("R4 R1 next pixel no sof", {2'b01, pval(fnum, 1)});
    endtask

    task automatic t_midframe_and_noadv();
        // pointer now 2, armed; pixel 2 without a frame start must be ignored
        beat(2, 6'h2A);
        idle(1);
        @(negedge clk);
        chk("R7 partial frame ignored", reg_data, 8'h00);
        rd_expect("R6 read with no data", 8'h00);
        frame(2);
        rd_expect("R6 pointer held at 2", {2'b01, pval(fnum, 2)});
    endtask

    task automatic t_stale();
        int held_f;
        frame(3);
        held_f = fnum;
        frame(3);
        frame(3);
        rd_expect("R8 held value not overwritten", {2'b01, pval(held_f, 3)});
    endtask

    task automatic t_write_wins();
        frame(4);
        @(negedge clk);
        reg_wr = 1; reg_rd = 1;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
        chk("R10 write wins clears valid", reg_data, 8'h00);
        frame(0);
        rd_expect("R10 pointer back at 0", {2'b11, pval(fnum, 0)});
    endtask

    task automatic t_dump_wrap();
        wr_pulse();
        for (int k = 0; k < NPIX; k++) begin
            frame(k);
            rd_expect(k == 0 ? "R5 dump start sof" : "R5 R4 dump pixel",
                      {(k == 0), 1'b1, pval(fnum, k)});
        end
        frame(0);
        rd_expect("R5 wrap shows sof again", {2'b11, pval(fnum, 0)});
        frame(1);
        rd_expect("R5 after wrap pixel 1", {2'b01, pval(fnum, 1)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write_first();
        t_midframe_and_noadv();
        t_stale();
        t_write_wins();
        t_dump_wrap();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule